// File: doc/BRIEF.md
# Bus Slave Busy-Response Arbiter

This block sits beside the bit-level front end of a PMBus/SMBus slave. It decides how a transaction is answered when it arrives while the device is still working on something else. The front end reports that a command has started, whether it is a read, and whether the command and data are legal. The arbiter answers with an acknowledge decision. It may also force every read byte to all ones, hold SCL low, or raise a sticky busy fault that pulls an active-low alert line down.

Three busy sources come in from the rest of the device: a general internal operation, an output-voltage transition and pending calculations. The arbiter keeps a handshake status byte with one not-busy bit per source, so host software can poll that byte until all three bits read as one. A command that arrives after that point is acknowledged with no collision handling. Clock stretching is used only when it is enabled in the configuration and a built-in meter finds that SCL is faster than 100 kHz. In every other case the NACK, all-ones or fault path handles the collision.

Top module: `pmb_busy_resp`

## Requirements
- R1: `status_byte[6]` reads 0 one clock after any of `busy_op`, `busy_vout` or `busy_calc` is high, and reads 1 one clock after all three are low. Bits 7 and 3..0 always read 0.
- R2: `status_byte[4]` is the registered inverse of `busy_vout`.
- R3: `status_byte[5]` is the registered inverse of `busy_calc`.
- R4: When `cmd_start` is sampled while `status_byte` reads 0x70, `resp_valid` pulses in the next cycle with `resp_ack` equal to `cmd_valid`. `rd_force_ff` drops to 0 and no fault is raised. An invalid command is therefore still NACKed.
- R5: When a command collides with a busy status, stretching is not in effect, and either the command is a write or `cfg_ctl[0]` is 0, the response is `resp_ack`=0.
- R6: When a read collides with a busy status, stretching is not in effect and `cfg_ctl[0]` is 1, the response is `resp_ack`=1 with `rd_force_ff`=1. `rd_force_ff` holds until the next response.
- R7: A collision handled without stretching sets `busy_fault` and drives `alert_n` low one cycle later if `cfg_ctl[2]` is 1. If `cfg_ctl[2]` is 0, neither output changes.
- R8: `busy_fault` and the low `alert_n` persist until a `clr_faults` pulse, which clears both in the next cycle.
- R9: Stretching is in effect when `cfg_ctl[1]` is 1 and the last measured SCL rising-edge period is below `FAST_LIMIT` clocks. A collision then raises `scl_stretch` in the next cycle, with no response and no fault while it is held.
- R10: `scl_stretch` drops one clock after all three busy inputs are low. In that same cycle `resp_valid` pulses with `resp_ack` equal to the held `cmd_valid`.
- R11: With `cfg_ctl[1]`=1 but a slow bus (period of at least `FAST_LIMIT` clocks), the collision takes the R5, R6 and R7 path instead of stretching.
- R12: After reset, `status_byte`=0x70, `alert_n`=1, and `busy_fault`, `scl_stretch`, `resp_valid` and `rd_force_ff` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | One-cycle pulse: a command has been received |
| cmd_is_read | input | 1 | The command is a read |
| cmd_valid | input | 1 | Command and data are legal |
| busy_op | input | 1 | An internal operation is running |
| busy_vout | input | 1 | The output voltage is in transition |
| busy_calc | input | 1 | Internal calculations are pending |
| cfg_ctl | input | 3 | [0] answer busy reads with all ones, [1] allow stretching, [2] raise fault on collision |
| scl_in | input | 1 | Raw SCL line, used only to measure speed |
| clr_faults | input | 1 | Pulse that clears the busy fault and the alert |
| resp_valid | output | 1 | One-cycle pulse: a response decision is ready |
| resp_ack | output | 1 | 1 = ACK, 0 = NACK, valid with resp_valid |
| rd_force_ff | output | 1 | Read data is to be replaced with 0xFF |
| scl_stretch | output | 1 | Request to hold SCL low |
| busy_fault | output | 1 | Sticky busy fault flag |
| alert_n | output | 1 | Active-low alert |
| status_byte | output | 8 | Handshake status: bit 6 chip not busy, bit 5 calculations done, bit 4 output settled |

## Verification
The stretch hold is the hardest case to reach from the ports. It needs the SCL meter to have latched a fast period first, so the bench toggles `scl_in` at a 20-clock period before the collision. It then holds the busy inputs for several cycles, checking that no response leaks out, and checks the release cycle exactly. The slow-bus case uses the same configuration, after a few 2000-clock SCL periods, to show that the collision falls back to the fault path.

// File: rtl/pmb_busy_pkg.sv
package pmb_busy_pkg;
  localparam int CFG_W           = 3;
  localparam int CFG_FF_BIT      = 0;
  localparam int CFG_STRETCH_BIT = 1;
  localparam int CFG_FAULT_BIT   = 2;

  localparam int ST_SETTLED_BIT  = 4;
  localparam int ST_CALC_BIT     = 5;
  localparam int ST_IDLE_BIT     = 6;
  localparam int NUM_SRC         = 3;

  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_HOLD = 1'b1
  } arb_state_e;
endpackage

// File: rtl/pmb_scl_meter.sv
module pmb_scl_meter #(
  parameter int FAST_LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  output logic bus_fast
);
  localparam int CW = $clog2(FAST_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(FAST_LIMIT);

  logic [2:0]    sync_q, sync_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          seen_q, seen_d;
  logic          fast_q, fast_d;
  logic          rise;

  always_comb begin
    sync_d = {sync_q[1:0], scl_in};
    rise   = sync_q[1] & ~sync_q[2];
    seen_d = seen_q | rise;
    fast_d = fast_q;
    if (rise) begin
      cnt_d  = CW'(1);
      fast_d = seen_q & (cnt_q < LIM);
    end else if (cnt_q == LIM) begin
      cnt_d = cnt_q;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
      seen_q <= 1'b0;
      fast_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
      fast_q <= fast_d;
    end
  end

  assign bus_fast = fast_q;
endmodule

// File: rtl/pmb_busy_status.sv
module pmb_busy_status
  import pmb_busy_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy_op,
  input  logic       busy_vout,
  input  logic       busy_calc,
  output logic [7:0] status_byte,
  output logic       any_busy_now,
  output logic       all_clear
);
  logic [NUM_SRC-1:0] nb_q, nb_d;

  always_comb begin
    any_busy_now = busy_op | busy_vout | busy_calc;
    nb_d[0] = ~busy_vout;
    nb_d[1] = ~busy_calc;
    nb_d[2] = ~any_busy_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nb_q <= '1;
    else        nb_q <= nb_d;
  end

  always_comb begin
    status_byte                 = 8'h00;
    status_byte[ST_SETTLED_BIT] = nb_q[0];
    status_byte[ST_CALC_BIT]    = nb_q[1];
    status_byte[ST_IDLE_BIT]    = nb_q[2];
    all_clear                   = &nb_q;
  end
endmodule

// File: rtl/pmb_busy_arb.sv
module pmb_busy_arb
  import pmb_busy_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_is_read,
  input  logic             cmd_valid,
  input  logic             all_clear,
  input  logic             any_busy_now,
  input  logic             bus_fast,
  input  logic [CFG_W-1:0] cfg_ctl,
  input  logic             clr_faults,
  output logic             resp_valid,
  output logic             resp_ack,
  output logic             rd_force_ff,
  output logic             scl_stretch,
  output logic             busy_fault
);
  arb_state_e state_q, state_d;
  logic vld_q, vld_d, ack_q, ack_d, ff_q, ff_d, pend_q, pend_d, flt_q, flt_d;
  logic collide, stretch_ok;

  always_comb begin
    state_d    = state_q;
    vld_d      = 1'b0;
    ack_d      = 1'b0;
    ff_d       = ff_q;
    pend_d     = pend_q;
    collide    = 1'b0;
    stretch_ok = cfg_ctl[CFG_STRETCH_BIT] & bus_fast;
    case (state_q)
      ARB_IDLE: begin
        if (cmd_start) begin
          if (all_clear) begin
            vld_d = 1'b1;
            ack_d = cmd_valid;
            ff_d  = 1'b0;
          end else if (stretch_ok) begin
            state_d = ARB_HOLD;
            pend_d  = cmd_valid;
          end else begin
            collide = 1'b1;
            vld_d   = 1'b1;
            ack_d   = cmd_is_read & cfg_ctl[CFG_FF_BIT];
            ff_d    = cmd_is_read & cfg_ctl[CFG_FF_BIT];
          end
        end
      end
      ARB_HOLD: begin
        if (!any_busy_now) begin
          state_d = ARB_IDLE;
          vld_d   = 1'b1;
          ack_d   = pend_q;
          ff_d    = 1'b0;
        end
      end
      default: state_d = ARB_IDLE;
    endcase
    if (collide && cfg_ctl[CFG_FAULT_BIT]) flt_d = 1'b1;
    else if (clr_faults)                    flt_d = 1'b0;
    else                                    flt_d = flt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      vld_q   <= 1'b0;
      ack_q   <= 1'b0;
      ff_q    <= 1'b0;
      pend_q  <= 1'b0;
      flt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      vld_q   <= vld_d;
      ack_q   <= ack_d;
      ff_q    <= ff_d;
      pend_q  <= pend_d;
      flt_q   <= flt_d;
    end
  end

  assign resp_valid  = vld_q;
  assign resp_ack    = ack_q;
  assign rd_force_ff = ff_q;
  assign scl_stretch = (state_q == ARB_HOLD);
  assign busy_fault  = flt_q;
endmodule

// File: rtl/pmb_busy_resp.sv
module pmb_busy_resp
  import pmb_busy_pkg::*;
#(
  parameter int FAST_LIMIT = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_is_read,
  input  logic             cmd_valid,
  input  logic             busy_op,
  input  logic             busy_vout,
  input  logic             busy_calc,
  input  logic [CFG_W-1:0] cfg_ctl,
  input  logic             scl_in,
  input  logic             clr_faults,
  output logic             resp_valid,
  output logic             resp_ack,
  output logic             rd_force_ff,
  output logic             scl_stretch,
  output logic             busy_fault,
  output logic             alert_n,
  output logic [7:0]       status_byte
);
  logic bus_fast, any_busy_now, all_clear;

  pmb_scl_meter #(.FAST_LIMIT(FAST_LIMIT)) u_meter (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .bus_fast(bus_fast)
  );

  pmb_busy_status u_status (
    .clk(clk), .rst_n(rst_n), .busy_op(busy_op), .busy_vout(busy_vout),
    .busy_calc(busy_calc), .status_byte(status_byte),
    .any_busy_now(any_busy_now), .all_clear(all_clear)
  );

  pmb_busy_arb u_arb (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_is_read(cmd_is_read),
    .cmd_valid(cmd_valid), .all_clear(all_clear), .any_busy_now(any_busy_now),
    .bus_fast(bus_fast), .cfg_ctl(cfg_ctl), .clr_faults(clr_faults),
    .resp_valid(resp_valid), .resp_ack(resp_ack), .rd_force_ff(rd_force_ff),
    .scl_stretch(scl_stretch), .busy_fault(busy_fault)
  );

  assign alert_n = ~busy_fault;
endmodule

// File: rtl/pmb_busy_resp_chk.sv
module pmb_busy_resp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_start,
  input logic       cmd_valid,
  input logic       busy_op,
  input logic       busy_vout,
  input logic       busy_calc,
  input logic       clr_faults,
  input logic       resp_valid,
  input logic       resp_ack,
  input logic       scl_stretch,
  input logic       busy_fault,
  input logic       alert_n,
  input logic [7:0] status_byte
);
  // R1
  chip_busy_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_op | busy_vout | busy_calc) |=> !status_byte[6]);
  // R4
  idle_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && status_byte == 8'h70 && !scl_stretch) |=> (resp_valid && resp_ack == $past(cmd_valid)));
  // R9
  hold_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_stretch |-> (!resp_valid && $stable(busy_fault)));
  // R10
  release_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_stretch) |-> resp_valid);
  // R8
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_fault && !clr_faults) |=> (busy_fault && !alert_n));
endmodule

bind pmb_busy_resp pmb_busy_resp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_valid(cmd_valid),
  .busy_op(busy_op), .busy_vout(busy_vout), .busy_calc(busy_calc),
  .clr_faults(clr_faults), .resp_valid(resp_valid), .resp_ack(resp_ack),
  .scl_stretch(scl_stretch), .busy_fault(busy_fault), .alert_n(alert_n),
  .status_byte(status_byte)
);

// File: tb/pmb_busy_resp_bench.sv
module pmb_busy_resp_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic cmd_start, cmd_is_read, cmd_valid;
  logic busy_op, busy_vout, busy_calc;
  logic [2:0] cfg_ctl;
  logic scl_in, clr_faults;
  logic resp_valid, resp_ack, rd_force_ff, scl_stretch, busy_fault, alert_n;
  logic [7:0] status_byte;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct { logic ack; logic ff; string req; } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  pmb_busy_resp u_pmb_busy_resp (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_is_read(cmd_is_read),
    .cmd_valid(cmd_valid), .busy_op(busy_op), .busy_vout(busy_vout),
    .busy_calc(busy_calc), .cfg_ctl(cfg_ctl), .scl_in(scl_in),
    .clr_faults(clr_faults), .resp_valid(resp_valid), .resp_ack(resp_ack),
    .rd_force_ff(rd_force_ff), .scl_stretch(scl_stretch),
    .busy_fault(busy_fault), .alert_n(alert_n), .status_byte(status_byte)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (exp_q.size() != 0) check("R10 pending responses", 8'(exp_q.size()), 8'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // monitor: pops expected responses
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (exp_q.size() == 0) begin
        check("R4 unexpected response", 8'd1, 8'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.req, " ack"}, {7'd0, resp_ack}, {7'd0, e.ack});
        check({e.req, " ff"}, {7'd0, rd_force_ff}, {7'd0, e.ff});
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      check("watchdog", 8'd1, 8'd0);
      finish_run();
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // driver: pulse a command and push the expected response
  task automatic send_cmd(input logic rd, input logic vld, input logic push,
                          input logic eack, input logic eff, input string req);
    exp_t e;
    e.ack = eack; e.ff = eff; e.req = req;
    if (push) exp_q.push_back(e);
    cmd_start = 1'b1; cmd_is_read = rd; cmd_valid = vld;
    tick(1);
    cmd_start = 1'b0;
  endtask

  task automatic scl_run(input int half, input int periods);
    for (int i = 0; i < periods; i++) begin
      scl_in = 1'b0; tick(half);
      scl_in = 1'b1; tick(half);
    end
  endtask

  task automatic set_busy(input logic o, input logic v, input logic c);
    busy_op = o; busy_vout = v; busy_calc = c;
    tick(1);
  endtask

  initial begin
    rst_n = 1'b0; cmd_start = 0; cmd_is_read = 0; cmd_valid = 0;
    busy_op = 0; busy_vout = 0; busy_calc = 0; cfg_ctl = 3'b000;
    scl_in = 1'b1; clr_faults = 0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R12 reset state
    check("R12 status", status_byte, 8'h70);
    check("R12 outputs", {2'b0, alert_n, busy_fault, scl_stretch, resp_valid, rd_force_ff, 1'b0},
          {2'b0, 1'b1, 5'b0});

    // R1 R2 R3 status bits
    set_busy(1, 0, 0); check("R1 op busy", status_byte, 8'h30);
    set_busy(0, 1, 0); check("R2 vout busy", status_byte, 8'h20);
    set_busy(0, 0, 1); check("R3 calc busy", status_byte, 8'h10);
    set_busy(0, 0, 0); check("R1 all clear", status_byte, 8'h70);

    // R4 accept when not busy, valid and invalid
    send_cmd(0, 1, 1, 1, 0, "R4 idle write");
    tick(1);
    send_cmd(1, 0, 1, 0, 0, "R4 invalid nack");
    tick(1);

    // R5 busy write NACK, no fault
    cfg_ctl = 3'b001;
    set_busy(1, 0, 0);
    send_cmd(0, 1, 1, 0, 0, "R5 busy write");
    check("R7 no fault when disabled", {7'd0, busy_fault}, 8'd0);
    // R6 busy read returns all ones
    send_cmd(1, 1, 1, 1, 1, "R6 busy read");
    tick(3);
    check("R6 ff holds", {7'd0, rd_force_ff}, 8'd1);
    // R5 read with ff mode off
    cfg_ctl = 3'b100;
    send_cmd(1, 1, 1, 0, 0, "R5 busy read nack");
    // R7 fault raised
    check("R7 fault set", {6'd0, busy_fault, alert_n}, 8'b10);
    set_busy(0, 0, 0);
    tick(2);
    // R8 sticky
    check("R8 fault sticky", {6'd0, busy_fault, alert_n}, 8'b10);
    clr_faults = 1'b1; tick(1); clr_faults = 1'b0;
    check("R8 fault cleared", {6'd0, busy_fault, alert_n}, 8'b01);

    // R11 stretch enabled but slow bus
    cfg_ctl = 3'b110;
    scl_run(1000, 3);
    set_busy(0, 0, 1);
    send_cmd(0, 1, 1, 0, 0, "R11 slow bus");
    check("R11 no stretch", {7'd0, scl_stretch}, 8'd0);
    check("R11 fault", {7'd0, busy_fault}, 8'd1);
    clr_faults = 1'b1; tick(1); clr_faults = 1'b0;

    // R9 R10 fast bus stretch
    scl_run(10, 4);
    send_cmd(0, 1, 1, 1, 0, "R10 release ack");
    check("R9 stretch raised", {7'd0, scl_stretch}, 8'd1);
    tick(5);
    check("R9 held, no response", {7'd0, scl_stretch}, 8'd1);
    check("R9 queue pending", 8'(exp_q.size()), 8'd1);
    check("R9 no fault", {7'd0, busy_fault}, 8'd0);
    set_busy(0, 0, 0);
    check("R10 released", {7'd0, scl_stretch}, 8'd0);
    tick(1);

    // R10 invalid command held then NACKed, with a vout transition
    set_busy(0, 1, 0);
    send_cmd(1, 0, 1, 0, 0, "R10 release nack");
    tick(2);
    set_busy(0, 0, 0);
    check("R10 released vout", {7'd0, scl_stretch}, 8'd0);
    tick(2);

    done = 1'b1;
    finish_run();
  end
endmodule